// File: doc/BRIEF.md
# Nonvolatile Access Guard and Slave Address Control

This block sits between a host register interface and the engine that manages two nonvolatile register blocks. For every host write it decides whether the write may reach its target. Writes are refused while a copy to nonvolatile storage is running. Writes are also refused once a block has been permanently locked. A write to the slave-address location is refused unless a separate enable bit has been set first. No error is raised for a refused write: the target simply keeps its old value.

Locking takes two steps and can happen only once. The host first writes 1 to the arm bit of the access register, and its very next command must be a lock command naming a block. Any other command cancels the arm. The block also keeps a working (shadow) copy of the 7-bit bus slave address, which the bus engine uses at once. The shadow address is offered to storage for saving only when a copy of block 1 completes. A reset reloads the shadow address from the stored value, and reloads the lock flags from storage in the same way.

Top module: `nvm_guard`

## Requirements
- R1: During reset (synchronous, `rst_n` low) the copy flag, the arm bit and the slave-address enable are cleared. The lock flags load from `nv_lock_in`, and the shadow address loads from `nv_addr_in`.
- R2: A copy command (code C0h for block 0, C1h for block 1) issued while idle sets the copy flag from the next cycle. The flag is `copy_busy`, and also bit 7 of the access register at 1Fh. The flag stays set until `copy_done` is seen.
- R3: While the copy flag is 1, `wr_en` stays low for addresses 20h–2Fh and 60h–7Fh, and the stored values at those addresses do not change. Writes to all other addresses still pass.
- R4: Writing a value with bit 6 set to 1Fh arms locking, and reading 1Fh then shows bit 6 as 1. A following command that is not a lock command clears the arm and changes no lock flag.
- R5: A lock command issued while armed sets one lock flag: D0h sets bit 0 (block 0) and D1h sets bit 1 (block 1). The same command clears the arm.
- R6: A lock command issued while not armed has no effect on the lock flags.
- R7: Lock flags are never cleared, including by writes to 1Fh. A set bit 0 blocks writes to 20h–2Fh, and a set bit 1 blocks writes to 60h–7Fh. The other block is not affected.
- R8: A write to 7Eh is accepted only while bit 1 of the feature register at 15h is 1. That bit resets to 0.
- R9: An accepted write to 7Eh changes `slave_addr` to write-data bits 7:1 from the next cycle. A read of 7Eh returns the slave address in bits 7:1 and the reserved bit in bit 0.
- R10: `commit_we` is high in the cycle where `copy_done` ends a block 1 copy, and `slave_addr` then carries the value to store. `commit_we` is never high when a block 0 copy ends.
- R11: A reset before a block 1 copy brings back the last committed slave address, because the shadow copy is reloaded from storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset (power cycle) |
| nv_addr_in | input | 7 | Slave address currently held in storage |
| nv_lock_in | input | 2 | Lock flags currently held in storage |
| reg_addr | input | 8 | Host register address |
| reg_wdata | input | 8 | Host write data |
| reg_we | input | 1 | Host write strobe |
| rd_data | output | 8 | Read value for 1Fh, 15h and 7Eh, zero elsewhere |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 8 | Command code |
| copy_done | input | 1 | Storage engine finished the copy |
| copy_busy | output | 1 | Copy flag |
| copy_blk1 | output | 1 | Block being copied is block 1 |
| wr_en | output | 1 | Qualified write enable for the current address |
| slave_addr | output | 7 | Active (shadow) slave address |
| lock_flags | output | 2 | Permanent lock flags, bit 0 = block 0 |
| commit_we | output | 1 | Store slave address into nonvolatile storage |

## Verification
A wrong arm state shows up on the first lock command after it: either a lock flag appears that should not, or a lock flag is missing. In both cases it is visible on `lock_flags` and on `wr_en` for the affected range in the next cycle. A copy flag stuck high or stuck low is visible at once on `wr_en` for any write into a storage range. A wrong shadow address shows up on `slave_addr` in the cycle after the write. A missed commit shows up only after the next reset, when the old address returns.

// File: rtl/nvm_guard.sv
module nvm_guard #(
  parameter logic [7:0] ACC_ADDR  = 8'h1F,
  parameter logic [7:0] FEAT_ADDR = 8'h15,
  parameter logic [7:0] SA_ADDR   = 8'h7E,
  parameter logic [7:0] B0_LO     = 8'h20,
  parameter logic [7:0] B0_HI     = 8'h2F,
  parameter logic [7:0] B1_LO     = 8'h60,
  parameter logic [7:0] B1_HI     = 8'h7F,
  parameter logic [7:0] CMD_COPY0 = 8'hC0,
  parameter logic [7:0] CMD_COPY1 = 8'hC1,
  parameter logic [7:0] CMD_LOCK0 = 8'hD0,
  parameter logic [7:0] CMD_LOCK1 = 8'hD1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [6:0] nv_addr_in,
  input  logic [1:0] nv_lock_in,
  input  logic [7:0] reg_addr,
  input  logic [7:0] reg_wdata,
  input  logic       reg_we,
  output logic [7:0] rd_data,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_code,
  input  logic       copy_done,
  output logic       copy_busy,
  output logic       copy_blk1,
  output logic       wr_en,
  output logic [6:0] slave_addr,
  output logic [1:0] lock_flags,
  output logic       commit_we
);
  logic       busy, blk1, arm, sawe;
  logic [1:0] lock;
  logic [7:0] sa_q;

  wire in_b0   = (reg_addr >= B0_LO) && (reg_addr <= B0_HI);
  wire in_b1   = (reg_addr >= B1_LO) && (reg_addr <= B1_HI);
  wire is_copy = (cmd_code == CMD_COPY0) || (cmd_code == CMD_COPY1);
  wire blocked = (busy && (in_b0 || in_b1)) || (lock[0] && in_b0) ||
                 (lock[1] && in_b1) || (reg_addr == SA_ADDR && !sawe);

  assign wr_en      = reg_we && !blocked;
  assign copy_busy  = busy;
  assign copy_blk1  = blk1;
  assign lock_flags = lock;
  assign slave_addr = sa_q[7:1];
  assign commit_we  = busy && copy_done && blk1;

  always_comb begin
    case (reg_addr)
      ACC_ADDR:  rd_data = {busy, arm, 4'b0, lock};
      FEAT_ADDR: rd_data = {6'b0, sawe, 1'b0};
      SA_ADDR:   rd_data = sa_q;
      default:   rd_data = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      blk1 <= 1'b0;
      arm  <= 1'b0;
      sawe <= 1'b0;
      lock <= nv_lock_in;
      sa_q <= {nv_addr_in, 1'b0};
    end else begin
      if (busy && copy_done)
        busy <= 1'b0;
      else if (!busy && cmd_valid && is_copy) begin
        busy <= 1'b1;
        blk1 <= (cmd_code == CMD_COPY1);
      end
      if (cmd_valid && arm && cmd_code == CMD_LOCK0) lock[0] <= 1'b1;
      if (cmd_valid && arm && cmd_code == CMD_LOCK1) lock[1] <= 1'b1;
      if (wr_en && reg_addr == ACC_ADDR && reg_wdata[6])
        arm <= 1'b1;
      else if (cmd_valid)
        arm <= 1'b0;
      if (wr_en && reg_addr == FEAT_ADDR) sawe <= reg_wdata[1];
      if (wr_en && reg_addr == SA_ADDR) sa_q <= reg_wdata;
    end
  end
endmodule

// File: rtl/nvm_guard_chk.sv
module nvm_guard_chk #(
  parameter logic [7:0] SA_ADDR   = 8'h7E,
  parameter logic [7:0] B0_LO     = 8'h20,
  parameter logic [7:0] B0_HI     = 8'h2F,
  parameter logic [7:0] B1_LO     = 8'h60,
  parameter logic [7:0] B1_HI     = 8'h7F,
  parameter logic [7:0] CMD_LOCK0 = 8'hD0,
  parameter logic [7:0] CMD_LOCK1 = 8'hD1
) (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] reg_addr,
  input logic [7:0] reg_wdata,
  input logic       reg_we,
  input logic       cmd_valid,
  input logic [7:0] cmd_code,
  input logic       copy_done,
  input logic       copy_busy,
  input logic       wr_en,
  input logic [6:0] slave_addr,
  input logic [1:0] lock_flags,
  input logic       commit_we,
  input logic       arm
);
  logic seen = 1'b0;
  always_ff @(posedge clk) seen <= rst_n;

  wire c_b0 = (reg_addr >= B0_LO) && (reg_addr <= B0_HI);
  wire c_b1 = (reg_addr >= B1_LO) && (reg_addr <= B1_HI);
  wire sa_wr = reg_we && wr_en && (reg_addr == SA_ADDR);
  wire lk_cmd = cmd_valid && (cmd_code == CMD_LOCK0 || cmd_code == CMD_LOCK1);

  AST_COPY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (copy_busy && (c_b0 || c_b1)) |-> !wr_en); // R3
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    1'b1 |=> ((lock_flags & $past(lock_flags)) == $past(lock_flags))); // R7
  AST_LOCK0_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_flags[0] && c_b0) |-> !wr_en); // R7
  AST_LOCK1_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_flags[1] && c_b1) |-> !wr_en); // R7
  AST_UNARMED_LOCK: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    (lk_cmd && !arm) |=> (lock_flags == $past(lock_flags))); // R6
  AST_SA_TAKE: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    sa_wr |=> (slave_addr == $past(reg_wdata[7:1]))); // R9
  AST_SA_HOLD: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    !sa_wr |=> $stable(slave_addr)); // R8
  AST_COMMIT_END: assert property (@(posedge clk) disable iff (!rst_n)
    commit_we |-> (copy_busy && copy_done)); // R10
endmodule

bind nvm_guard nvm_guard_chk #(
  .SA_ADDR(SA_ADDR), .B0_LO(B0_LO), .B0_HI(B0_HI), .B1_LO(B1_LO), .B1_HI(B1_HI),
  .CMD_LOCK0(CMD_LOCK0), .CMD_LOCK1(CMD_LOCK1)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .reg_we(reg_we), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
  .copy_done(copy_done), .copy_busy(copy_busy), .wr_en(wr_en),
  .slave_addr(slave_addr), .lock_flags(lock_flags), .commit_we(commit_we),
  .arm(arm)
);

// File: tb/test_nvm_guard.sv
module test_nvm_guard;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] nv_addr = 7'h34;
  logic [1:0] nv_lock = 2'b00;
  logic [7:0] reg_addr = 8'h00, reg_wdata = 8'h00, cmd_code = 8'h00;
  logic       reg_we = 1'b0, cmd_valid = 1'b0, copy_done = 1'b0;
  logic [7:0] rd_data;
  logic       copy_busy, copy_blk1, wr_en, commit_we;
  logic [6:0] slave_addr;
  logic [1:0] lock_flags;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  nvm_guard i_nvm_guard (
    .clk(clk), .rst_n(rst_n), .nv_addr_in(nv_addr), .nv_lock_in(nv_lock),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we), .rd_data(rd_data),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .copy_done(copy_done),
    .copy_busy(copy_busy), .copy_blk1(copy_blk1), .wr_en(wr_en),
    .slave_addr(slave_addr), .lock_flags(lock_flags), .commit_we(commit_we)
  );

  always @(posedge clk) begin
    if (commit_we) nv_addr <= slave_addr;
    if (rst_n) nv_lock <= lock_flags;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, input logic exp_en, input string tag);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    #1 chk(tag, wr_en, exp_en);
    @(negedge clk) reg_we = 1'b0;
    #1;
  endtask

  task automatic cmd(input logic [7:0] c);
    @(negedge clk);
    cmd_code = c; cmd_valid = 1'b1;
    @(negedge clk) cmd_valid = 1'b0;
    #1;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
    reg_addr = a;
    #1 chk(tag, rd_data, exp);
  endtask

  task automatic finish_copy(input logic exp_commit, input string tag);
    @(negedge clk) copy_done = 1'b1;
    #1 chk(tag, commit_we, exp_commit);
    @(negedge clk) copy_done = 1'b0;
    #1 chk("R2 busy clears", copy_busy, 1'b0);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 busy", copy_busy, 1'b0);
    chk("R1 slave addr", slave_addr, 7'h34);
    rd(8'h1F, 8'h00, "R1 access reg");
    rd(8'h15, 8'h00, "R1 feature reg");
  endtask

  task automatic t_slave_addr();
    wr(8'h7E, 8'hA6, 1'b0, "R8 gated write");
    chk("R8 addr kept", slave_addr, 7'h34);
    wr(8'h15, 8'h02, 1'b1, "R8 enable write");
    rd(8'h15, 8'h02, "R8 enable read");
    wr(8'h7E, 8'hA7, 1'b1, "R8 write accepted");
    chk("R9 new addr", slave_addr, 7'h53);
    rd(8'h7E, 8'hA7, "R9 readback");
  endtask

  task automatic t_power();
    do_reset();
    chk("R11 restore", slave_addr, 7'h34);
    rd(8'h15, 8'h00, "R1 enable cleared");
    wr(8'h15, 8'h02, 1'b1, "R8 enable write");
    wr(8'h7E, 8'hA6, 1'b1, "R9 write");
    cmd(8'hC1);
    chk("R2 busy", copy_busy, 1'b1);
    rd(8'h1F, 8'h80, "R2 flag bit7");
    finish_copy(1'b1, "R10 commit b1");
    cmd(8'hC0);
    finish_copy(1'b0, "R10 no commit b0");
    do_reset();
    chk("R11 committed kept", slave_addr, 7'h53);
  endtask

  task automatic t_copy_block();
    wr(8'h15, 8'h02, 1'b1, "R8 enable write");
    cmd(8'hC0);
    chk("R2 busy", copy_busy, 1'b1);
    wr(8'h25, 8'h11, 1'b0, "R3 block0 blocked");
    wr(8'h7E, 8'h20, 1'b0, "R3 block1 blocked");
    chk("R3 addr unchanged", slave_addr, 7'h53);
    wr(8'h10, 8'h11, 1'b1, "R3 other addr passes");
    cmd(8'hC1);
    chk("R2 busy held", copy_busy, 1'b1);
    finish_copy(1'b0, "R10 b0 copy no commit");
    wr(8'h25, 8'h11, 1'b1, "R3 released");
  endtask

  task automatic t_arm();
    wr(8'h1F, 8'h40, 1'b1, "R4 arm write");
    rd(8'h1F, 8'h40, "R4 armed");
    cmd(8'h00);
    rd(8'h1F, 8'h00, "R4 cancelled");
    cmd(8'hD0);
    rd(8'h1F, 8'h00, "R6 unarmed lock");
    wr(8'h25, 8'h11, 1'b1, "R6 block0 open");
  endtask

  task automatic t_lock();
    wr(8'h1F, 8'h40, 1'b1, "R5 arm");
    cmd(8'hD0);
    rd(8'h1F, 8'h01, "R5 lock0 set arm clear");
    wr(8'h25, 8'h11, 1'b0, "R7 block0 locked");
    wr(8'h65, 8'h11, 1'b1, "R7 block1 open");
    wr(8'h1F, 8'h00, 1'b1, "R7 clear attempt");
    rd(8'h1F, 8'h01, "R7 sticky");
    wr(8'h1F, 8'h40, 1'b1, "R5 arm");
    cmd(8'hD1);
    chk("R5 lock1 set", lock_flags, 2'b11);
    wr(8'h7E, 8'h20, 1'b0, "R7 addr locked");
    chk("R7 addr unchanged", slave_addr, 7'h53);
    do_reset();
    chk("R1 locks reload", lock_flags, 2'b11);
  endtask

  initial begin
    t_reset();
    t_slave_addr();
    t_power();
    t_copy_block();
    t_arm();
    t_lock();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule